// File: doc/BRIEF.md
# SONET Frame and Byte Aligner

This block sits behind a clock and data recovery stage and takes the recovered line as one bit per clock, most significant bit of each byte first. It looks for the SONET framing word at every bit position. The framing word is a run of three 0xF6 bytes followed at once by three 0x28 bytes. When the word appears, the aligner fixes the byte boundary at the end of the last 0x28 byte and turns the serial stream into 8-bit words. Each word comes with a one-clock valid strobe. The strobe repeats every eight bit clocks, so the word rate is one eighth of the line rate.

Two status inputs from the receive path control the aligner. An out-of-frame indication sends it back to searching. A loss-of-signal indication also sends it back to searching, and it forces every word to zero while the strobe keeps running. A single-cycle frame pulse marks the word that carries the final 0x28 byte. The frame pulse lets a downstream framer find the start of the transport overhead.

Top module: `sonet_byte_aligner`

## Requirements
- R1: A synchronous active-high reset clears the bit history and the bit-phase counter. While `rst` is high and on the first clock after it, `locked_o`, `frame_pulse_o` and `byte_vld_o` are low and `byte_o` is 0x00.
- R2: In the hunting state the framing word can be found at any of the eight bit offsets. The framing word is the most recent 48 bits equal to 0xF6F6F6282828, oldest bit first. `locked_o` goes high on the clock after the clock that samples the final bit of the word.
- R3: Once locked, each group of eight serial bits that follows the framing word appears on `byte_o`, with the first received bit in bit 7. The word appears with `byte_vld_o` high on the clock after the clock that samples the group's last bit.
- R4: `frame_pulse_o` is high for exactly one strobe cycle. That cycle is the one whose `byte_o` is the third 0x28 byte, and `locked_o` is high in it.
- R5: While locked, `byte_vld_o` is high on exactly one clock in every eight.
- R6: While locked, a framing word that ends on any bit other than the held byte boundary is ignored. `locked_o` stays high and no frame pulse is produced.
- R7: While locked, a framing word that ends on the held byte boundary produces a frame pulse again.
- R8: `oof_i` high for one clock returns the aligner to hunting on the next clock. While `oof_i` is held high, no lock and no frame pulse occur, even when the framing word is present.
- R9: A word captured while `los_i` is high is presented as 0x00, and `byte_vld_o` keeps its normal cadence.
- R10: `los_i` high returns the aligner to hunting on the next clock. While `los_i` is held high, the framing word neither locks the aligner nor produces a frame pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ser_bit_i | input | 1 | Recovered serial data bit |
| oof_i | input | 1 | Out-of-frame request; forces the search to restart |
| los_i | input | 1 | Loss of signal; mutes the words and forces hunting |
| byte_o | output | 8 | Aligned parallel word, first received bit in bit 7 |
| byte_vld_o | output | 1 | One-clock strobe marking a new word on `byte_o` |
| frame_pulse_o | output | 1 | One-strobe pulse on the word holding the last 0x28 byte |
| locked_o | output | 1 | High while the byte boundary is held |

## Verification
The framing word is placed after every bit offset from zero to seven. A design that compared only at its free-running byte phase would miss most of these offsets. The bench sends a framing word shifted by three bits during lock and checks that the byte boundary is held; a design that re-hunted while locked would jump phase there and raise a pulse. It also sends a correctly aligned repeat during lock to catch a design that raises the frame pulse only at first lock. Status tests pulse `oof_i` for a single clock, hold `oof_i` and `los_i` across a framing word, and raise `los_i` in mid-payload. These catch a design that drops the strobe instead of zeroing the data, or one that locks while the line is lost.

// File: rtl/sba_pkg.sv
package sba_pkg;

    localparam int unsigned SBA_BYTE_W  = 8;
    localparam int unsigned SBA_A1_RUN  = 3;
    localparam int unsigned SBA_A2_RUN  = 3;
    localparam logic [7:0]  SBA_A1_BYTE = 8'hF6;
    localparam logic [7:0]  SBA_A2_BYTE = 8'h28;

    typedef enum logic [0:0] {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } align_state_e;

    // Per-cycle capture control handed from the controller to the output stage
    typedef struct packed {
        logic strobe;   // capture a word on this clock
        logic fpulse;   // captured word closes a framing run
        logic mute;     // captured word is forced to zero
    } cap_ctl_t;

    function automatic logic hold_off(input logic oof, input logic los);
        return oof | los;
    endfunction

endpackage

// File: rtl/sba_pattern_match.sv
module sba_pattern_match
    import sba_pkg::*;
#(
    parameter int unsigned       BYTE_W = SBA_BYTE_W,
    parameter int unsigned       A1_RUN = SBA_A1_RUN,
    parameter int unsigned       A2_RUN = SBA_A2_RUN,
    parameter logic [BYTE_W-1:0] A1_VAL = SBA_A1_BYTE,
    parameter logic [BYTE_W-1:0] A2_VAL = SBA_A2_BYTE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_i,
    output logic              match_o,
    output logic [BYTE_W-1:0] recent_byte_o
);
    localparam int unsigned SLOTS = A1_RUN + A2_RUN;
    localparam int unsigned HIST_W = SLOTS * BYTE_W;

    logic [HIST_W-1:0] hist_q;
    logic [SLOTS-1:0]  slot_hit;

    // Newest bit enters at bit 0; the oldest framing byte ends up on top
    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else begin
            hist_q <= {hist_q[HIST_W-2:0], bit_i};
        end
    end

    // Slot 0 is the most recent byte; the lowest A2_RUN slots hold the second value
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        localparam logic [BYTE_W-1:0] SLOT_REF = (s < A2_RUN) ? A2_VAL : A1_VAL;
        assign slot_hit[s] = (hist_q[s*BYTE_W +: BYTE_W] == SLOT_REF);
    end

    assign match_o       = &slot_hit;
    assign recent_byte_o = hist_q[BYTE_W-1:0];

endmodule

// File: rtl/sba_phase_ctr.sv
module sba_phase_ctr
    import sba_pkg::*;
#(
    parameter int unsigned BYTE_W = SBA_BYTE_W
) (
    input  logic clk,
    input  logic rst,
    input  logic realign_i,
    output logic boundary_o
);
    localparam int unsigned PH_W  = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(BYTE_W - 1);
    localparam logic [PH_W-1:0] PH_ONE  = PH_W'(1);

    logic [PH_W-1:0] phase_q;

    // phase_q counts bits of the current word already in the history
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (realign_i) begin
            phase_q <= PH_ONE;
        end else if (phase_q == PH_LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PH_ONE;
        end
    end

    assign boundary_o = (phase_q == '0);

endmodule

// File: rtl/sba_align_ctrl.sv
module sba_align_ctrl
    import sba_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         match_i,
    input  logic         boundary_i,
    input  logic         oof_i,
    input  logic         los_i,
    output align_state_e state_o,
    output logic         realign_o,
    output cap_ctl_t     ctl_o
);
    align_state_e state_q;
    align_state_e state_d;
    logic         blocked;
    logic         take_lock;

    assign blocked   = hold_off(oof_i, los_i);
    assign take_lock = (state_q == ST_HUNT) && match_i && !blocked;

    always_comb begin
        state_d = state_q;
        if (blocked) begin
            state_d = ST_HUNT;
        end else if (take_lock) begin
            state_d = ST_LOCK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        ctl_o.strobe = boundary_i || take_lock;
        ctl_o.fpulse = ctl_o.strobe && match_i && !blocked;
        ctl_o.mute   = los_i;
    end

    assign realign_o = take_lock;
    assign state_o   = state_q;

endmodule

// File: rtl/sba_out_stage.sv
module sba_out_stage
    import sba_pkg::*;
#(
    parameter int unsigned BYTE_W = SBA_BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  cap_ctl_t          ctl_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              vld_o,
    output logic              fpulse_o
);
    logic [BYTE_W-1:0] word_q;
    logic              vld_q;
    logic              fp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            vld_q  <= 1'b0;
            fp_q   <= 1'b0;
        end else begin
            vld_q <= ctl_i.strobe;
            fp_q  <= ctl_i.fpulse;
            if (ctl_i.strobe) begin
                word_q <= ctl_i.mute ? '0 : byte_i;
            end
        end
    end

    assign byte_o   = word_q;
    assign vld_o    = vld_q;
    assign fpulse_o = fp_q;

endmodule

// File: rtl/sonet_byte_aligner.sv
module sonet_byte_aligner
    import sba_pkg::*;
#(
    parameter int unsigned       BYTE_W = SBA_BYTE_W,
    parameter int unsigned       A1_RUN = SBA_A1_RUN,
    parameter int unsigned       A2_RUN = SBA_A2_RUN,
    parameter logic [BYTE_W-1:0] A1_VAL = SBA_A1_BYTE,
    parameter logic [BYTE_W-1:0] A2_VAL = SBA_A2_BYTE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_bit_i,
    input  logic              oof_i,
    input  logic              los_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_vld_o,
    output logic              frame_pulse_o,
    output logic              locked_o
);
    logic              hit;
    logic [BYTE_W-1:0] cur_byte;
    logic              at_boundary;
    logic              realign;
    align_state_e      state;
    cap_ctl_t          cap_ctl;

    sba_pattern_match #(
        .BYTE_W(BYTE_W),
        .A1_RUN(A1_RUN),
        .A2_RUN(A2_RUN),
        .A1_VAL(A1_VAL),
        .A2_VAL(A2_VAL)
    ) u_match (
        .clk          (clk),
        .rst          (rst),
        .bit_i        (ser_bit_i),
        .match_o      (hit),
        .recent_byte_o(cur_byte)
    );

    sba_phase_ctr #(
        .BYTE_W(BYTE_W)
    ) u_phase (
        .clk       (clk),
        .rst       (rst),
        .realign_i (realign),
        .boundary_o(at_boundary)
    );

    sba_align_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .match_i   (hit),
        .boundary_i(at_boundary),
        .oof_i     (oof_i),
        .los_i     (los_i),
        .state_o   (state),
        .realign_o (realign),
        .ctl_o     (cap_ctl)
    );

    sba_out_stage #(
        .BYTE_W(BYTE_W)
    ) u_out (
        .clk     (clk),
        .rst     (rst),
        .ctl_i   (cap_ctl),
        .byte_i  (cur_byte),
        .byte_o  (byte_o),
        .vld_o   (byte_vld_o),
        .fpulse_o(frame_pulse_o)
    );

    assign locked_o = (state == ST_LOCK);

endmodule

// File: rtl/sba_checker.sv
module sba_checker #(
    parameter int unsigned       BYTE_W = 8,
    parameter logic [BYTE_W-1:0] A2_VAL = 8'h28
) (
    input logic              clk,
    input logic              rst,
    input logic              oof_i,
    input logic              los_i,
    input logic [BYTE_W-1:0] byte_o,
    input logic              byte_vld_o,
    input logic              frame_pulse_o,
    input logic              locked_o
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!locked_o && !byte_vld_o && !frame_pulse_o && byte_o == '0));

    p_pulse_on_a2_r4: assert property (@(posedge clk) disable iff (rst)
        frame_pulse_o |-> (byte_vld_o && byte_o == A2_VAL));

    p_pulse_locked_r4: assert property (@(posedge clk) disable iff (rst)
        frame_pulse_o |-> locked_o);

    p_pulse_single_r4: assert property (@(posedge clk) disable iff (rst)
        frame_pulse_o |=> !frame_pulse_o);

    p_strobe_gap_r5: assert property (@(posedge clk) disable iff (rst)
        (byte_vld_o && locked_o) |=> !byte_vld_o);

    p_oof_hunt_r8: assert property (@(posedge clk) disable iff (rst)
        oof_i |=> !locked_o);

    p_los_mute_r9: assert property (@(posedge clk) disable iff (rst)
        los_i |=> (!byte_vld_o || byte_o == '0));

    p_los_hunt_r10: assert property (@(posedge clk) disable iff (rst)
        los_i |=> (!locked_o && !frame_pulse_o));

endmodule

bind sonet_byte_aligner sba_checker #(
    .BYTE_W(BYTE_W),
    .A2_VAL(A2_VAL)
) u_sba_chk (
    .clk          (clk),
    .rst          (rst),
    .oof_i        (oof_i),
    .los_i        (los_i),
    .byte_o       (byte_o),
    .byte_vld_o   (byte_vld_o),
    .frame_pulse_o(frame_pulse_o),
    .locked_o     (locked_o)
);

// File: tb/sonet_byte_aligner_tb_top.sv
module sonet_byte_aligner_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam logic [7:0] A1 = 8'hF6;
    localparam logic [7:0] A2 = 8'h28;

    // Vector: {bit offset[3], payload0[8], payload1[8], los during payload1[1]}
    localparam int NVEC = 8;
    localparam logic [19:0] VECS [NVEC] = '{
        {3'd0, 8'hA5, 8'h3C, 1'b0},
        {3'd1, 8'h01, 8'h80, 1'b0},
        {3'd2, 8'h7E, 8'hC3, 1'b1},
        {3'd3, 8'hFF, 8'h00, 1'b0},
        {3'd4, 8'h5A, 8'h96, 1'b0},
        {3'd5, 8'h12, 8'h34, 1'b1},
        {3'd6, 8'hE7, 8'h18, 1'b0},
        {3'd7, 8'h9C, 8'h63, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_bit = 1'b0;
    logic       oof = 1'b0;
    logic       los = 1'b0;
    logic [7:0] byte_out;
    logic       byte_vld;
    logic       fpulse;
    logic       locked;

    int checks = 0;
    int fails  = 0;

    // observations of the most recent step / byte window
    logic [7:0] o_byte;
    logic       o_vld, o_fp, o_lock;
    int         w_vld;
    logic [7:0] w_data;
    logic       w_fp;
    logic       w_lock;

    always #(CLK_PERIOD/2) clk = ~clk;

    sonet_byte_aligner dut_i (
        .clk          (clk),
        .rst          (rst),
        .ser_bit_i    (ser_bit),
        .oof_i        (oof),
        .los_i        (los),
        .byte_o       (byte_out),
        .byte_vld_o   (byte_vld),
        .frame_pulse_o(fpulse),
        .locked_o     (locked)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // sample outputs away from the edge, then drive the next bit
    task automatic step(input logic b);
        @(negedge clk);
        o_byte = byte_out;
        o_vld  = byte_vld;
        o_fp   = fpulse;
        o_lock = locked;
        ser_bit = b;
    endtask

    task automatic send_byte(input logic [7:0] v);
        w_vld = 0;
        w_fp  = 1'b0;
        for (int i = 0; i < 8; i++) begin
            step(v[7-i]);
            if (o_vld) begin
                w_vld++;
                w_data = o_byte;
            end
            if (o_fp) w_fp = 1'b1;
        end
        w_lock = o_lock;
    endtask

    task automatic send_zeros(input int n);
        for (int i = 0; i < n; i++) step(1'b0);
    endtask

    task automatic send_frame_word();
        for (int i = 0; i < 3; i++) send_byte(A1);
        for (int i = 0; i < 3; i++) send_byte(A2);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ser_bit = 1'b0; oof = 1'b0; los = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // locks after `off` filler bits, then one payload byte; checks lock and pulse
    task automatic lock_up(input int off, input logic [7:0] p0);
        do_reset();
        send_zeros(off + 8);
        send_frame_word();
        send_byte(p0);
        chk(w_lock == 1'b1, "R2 lock after framing word", w_lock, 1);
        chk(w_fp == 1'b1 && w_data == A2, "R4 pulse with third A2 byte", w_data, A2);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(locked == 1'b0 && fpulse == 1'b0 && byte_vld == 1'b0, "R1 reset flags",
            {locked, fpulse, byte_vld}, 0);
        chk(byte_out == 8'h00, "R1 reset data", byte_out, 0);

        // Vector table: every bit offset, payload order, optional LOS mute
        for (int v = 0; v < NVEC; v++) begin
            logic [2:0] off;
            logic [7:0] p0, p1;
            logic       lv;
            {off, p0, p1, lv} = VECS[v];
            lock_up(int'(off), p0);
            if (lv) los = 1'b1;
            send_byte(p1);
            if (lv) begin
                chk(w_vld == 1 && w_data == 8'h00, "R9 muted word with strobe", w_data, 0);
                chk(w_lock == 1'b0, "R10 LOS drops lock", w_lock, 0);
            end else begin
                chk(w_vld == 1 && w_data == p0, "R3 first payload word", w_data, p0);
                chk(w_fp == 1'b0 && w_lock == 1'b1, "R5 one strobe no pulse", w_vld, 1);
            end
            send_byte(8'h00);
            chk(w_vld == 1 && w_data == (lv ? 8'h00 : p1), "R3 second payload word",
                w_data, lv ? 8'h00 : p1);
            los = 1'b0;
        end

        // R6: misaligned framing word while locked is ignored
        lock_up(2, 8'h11);
        send_zeros(3);
        for (int i = 0; i < 3; i++) begin
            send_byte(A1);
            chk(w_vld == 1 && !w_fp && w_lock, "R6 held phase during A1", w_vld, 1);
        end
        for (int i = 0; i < 4; i++) begin
            send_byte(i < 3 ? A2 : 8'h00);
            chk(w_fp == 1'b0, "R6 no pulse on shifted word", w_fp, 0);
            chk(w_lock == 1'b1 && w_vld == 1, "R5 cadence kept while locked", w_vld, 1);
        end

        // R7: aligned repeat gives another pulse
        lock_up(5, 8'h22);
        send_byte(8'h44);
        send_frame_word();
        chk(w_fp == 1'b0 && w_data == A2, "R7 no early pulse", w_fp, 0);
        send_byte(8'h66);
        chk(w_fp == 1'b1 && w_data == A2 && w_lock, "R7 repeat pulse", w_data, A2);

        // R8: one-clock OOF returns to hunting
        lock_up(1, 8'h33);
        oof = 1'b1;
        step(1'b0);
        oof = 1'b0;
        chk(o_lock == 1'b0, "R8 OOF pulse unlocks", o_lock, 0);
        // R8: OOF held across the framing word blocks lock
        oof = 1'b1;
        send_zeros(5);
        send_frame_word();
        send_byte(8'h00);
        chk(w_lock == 1'b0 && w_fp == 1'b0, "R8 held OOF blocks lock", w_lock, 0);
        oof = 1'b0;
        send_frame_word();
        send_byte(8'h00);
        chk(w_lock == 1'b1 && w_fp == 1'b1, "R8 relock after OOF", w_lock, 1);

        // R10: LOS held across the framing word blocks lock; R9 words muted
        do_reset();
        los = 1'b1;
        send_zeros(4);
        send_frame_word();
        send_byte(8'hAA);
        chk(w_lock == 1'b0 && w_fp == 1'b0, "R10 held LOS blocks lock", w_lock, 0);
        chk(w_vld == 1 && w_data == 8'h00, "R9 strobe runs muted", w_data, 0);
        los = 1'b0;

        // R1: reset in mid-lock
        lock_up(6, 8'h55);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(locked == 1'b0 && fpulse == 1'b0 && byte_vld == 1'b0 && byte_out == 8'h00,
            "R1 reset while locked", {locked, byte_vld}, 0);
        rst = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule